// File: doc/BRIEF.md
# Block-Bypass Two's-Complement Adder

This block adds two signed or unsigned 24-bit operands and a carry-in in a single combinational pass. It returns the 24-bit sum, the carry out of the top bit and a signed overflow flag. Inside, the operand bits are grouped into consecutive segments. Each segment is a short chain of full-adder cells.

Every segment ANDs its per-bit propagate terms. When the result is true, every bit of the segment propagates, and the carry that enters the segment goes straight to the next segment through a two-way multiplexer. It does not pass through the segment's own cells. When the result is false, the segment passes on the carry that leaves its own top cell.

The segment lengths are set by a packed parameter vector that holds one 8-bit field per segment, with segment 0 in the lowest field. Equal and unequal partitions are both legal. If the lengths do not add up to the operand width, elaboration stops. To subtract, the caller inverts the second operand and drives the carry-in high.

Top module: `csa_adder`

## Requirements
- R1: `sum_o` equals the low 24 bits of `a_i + b_i + cin_i`, where the operands are treated as unsigned.
- R2: `cout_o` equals bit 24 of the 25-bit result of `a_i + b_i + cin_i`.
- R3: `ovf_o` is 1 exactly when the carry into bit 23 differs from the carry out of bit 23.
- R4: `ovf_o` is 1 exactly when bit 23 of `a_i` equals bit 23 of `b_i` and bit 23 of `sum_o` differs from them. This gives the same flag as R3 for every input.
- R5: When `a_i ^ b_i` is all ones, every sum bit equals the inverse of `cin_i`, and `cout_o` equals `cin_i`.
- R6: With a carry generated at bit 0, propagate-only bits from bit 1 to bit 22 and a generate at bit 23, the adder still returns the exact sum and carry. The operands for this case are a=FFFFFF and b=800001.
- R7: Driving `b_i` with the inverse of an operand and `cin_i` high gives `a_i` minus that operand, modulo 2^24. In this case `cout_o` is 1 exactly when `a_i` is not less than that operand as an unsigned value.
- R8: Any partition whose lengths add up to the width gives results identical to the default partition of four 6-bit segments.
- R9: Zero operands give `sum_o` equal to `cin_i`, with `cout_o` and `ovf_o` both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 24 | First operand |
| b_i | input | 24 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 24 | Sum bits |
| cout_o | output | 1 | Carry out of bit 23 |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
The bench targets the long-carry case. A carry is generated at bit 0, crosses every middle segment through the bypass multiplexers and ends in the top segment. If a bypass select were wired to the wrong segment, or were ORed instead of ANDed, the carry would arrive at the wrong bits and this sum would be wrong. The all-propagate vectors cover the other case, where the carry-in must travel through every multiplexer to `cout_o`. A dropped bypass path would lose it. Overflow is checked at the four sign-bit combinations with and without a carry into bit 23, so a flag built from the wrong carry would miss either positive or negative overflow. A second instance with an unequal partition receives the same vectors, to catch offset errors when segment bases are computed from the length fields.

// File: rtl/csa_pkg.sv
package csa_pkg;
    localparam int unsigned LEN_BITS = 8;

    typedef struct packed {
        logic prop;
        logic gen;
    } pg_t;
endpackage

// File: rtl/csa_bit_cell.sv
module csa_bit_cell
    import csa_pkg::*;
(
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o,
    output logic p_o
);
    pg_t pg;

    always_comb begin
        pg.prop = a_i ^ b_i;
        pg.gen  = a_i & b_i;
        s_o     = pg.prop ^ c_i;
        c_o     = pg.gen | (pg.prop & c_i);
        p_o     = pg.prop;
    end
endmodule

// File: rtl/csa_skip_block.sv
module csa_skip_block #(
    parameter int unsigned LEN = 6
) (
    input  logic [LEN-1:0] a_i,
    input  logic [LEN-1:0] b_i,
    input  logic           cin_i,
    output logic [LEN-1:0] sum_o,
    output logic           cout_o
);
    logic [LEN:0]   rip;
    logic [LEN-1:0] prop;
    logic           seg_prop;

    assign rip[0] = cin_i;

    for (genvar i = 0; i < LEN; i++) begin : g_cell
        csa_bit_cell u_cell (
            .a_i (a_i[i]),
            .b_i (b_i[i]),
            .c_i (rip[i]),
            .s_o (sum_o[i]),
            .c_o (rip[i+1]),
            .p_o (prop[i])
        );
    end

    assign seg_prop = &prop;
    assign cout_o   = seg_prop ? cin_i : rip[LEN];
endmodule

// File: rtl/csa_ovf_detect.sv
module csa_ovf_detect (
    input  logic a_msb_i,
    input  logic b_msb_i,
    input  logic s_msb_i,
    input  logic c_out_i,
    output logic ovf_o
);
    logic c_into_msb;

    assign c_into_msb = s_msb_i ^ a_msb_i ^ b_msb_i;
    assign ovf_o      = c_into_msb ^ c_out_i;
endmodule

// File: rtl/csa_adder.sv
module csa_adder #(
    parameter int unsigned WIDTH   = 24,
    parameter int unsigned NBLK    = 4,
    parameter logic [NBLK*csa_pkg::LEN_BITS-1:0] BLK_LEN = {8'd6, 8'd6, 8'd6, 8'd6}
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             ovf_o
);
    localparam int unsigned LB = csa_pkg::LEN_BITS;

    function automatic int unsigned seg_base(input int unsigned k);
        int unsigned acc = 0;
        for (int unsigned j = 0; j < k; j++) acc += int'(BLK_LEN[j*LB +: LB]);
        return acc;
    endfunction

    localparam int unsigned TOTAL = seg_base(NBLK);

    if (TOTAL != WIDTH) begin : g_bad_partition
        $error("csa_adder: segment lengths do not add up to WIDTH");
    end

    logic [NBLK:0] seg_c;
    assign seg_c[0] = cin_i;

    for (genvar k = 0; k < NBLK; k++) begin : g_seg
        localparam int unsigned LO  = seg_base(k);
        localparam int unsigned LEN = int'(BLK_LEN[k*LB +: LB]);

        csa_skip_block #(.LEN(LEN)) u_seg (
            .a_i    (a_i[LO +: LEN]),
            .b_i    (b_i[LO +: LEN]),
            .cin_i  (seg_c[k]),
            .sum_o  (sum_o[LO +: LEN]),
            .cout_o (seg_c[k+1])
        );
    end

    assign cout_o = seg_c[NBLK];

    csa_ovf_detect u_ovf (
        .a_msb_i (a_i[WIDTH-1]),
        .b_msb_i (b_i[WIDTH-1]),
        .s_msb_i (sum_o[WIDTH-1]),
        .c_out_i (seg_c[NBLK]),
        .ovf_o   (ovf_o)
    );
endmodule

// File: rtl/csa_adder_chk.sv
module csa_adder_chk #(
    parameter int unsigned WIDTH = 24
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             cin_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             cout_o,
    input logic             ovf_o
);
    logic [WIDTH:0] ref_full;
    logic           known;

    always_comb begin
        ref_full = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
        known    = !$isunknown({a_i, b_i, cin_i, sum_o, cout_o, ovf_o});
        if (known) begin
            assert_sum_R1: assert (sum_o == ref_full[WIDTH-1:0]);
            assert_cout_R2: assert (cout_o == ref_full[WIDTH]);
            assert_sign_rule_R4: assert (ovf_o ==
                ((a_i[WIDTH-1] == b_i[WIDTH-1]) && (sum_o[WIDTH-1] != a_i[WIDTH-1])));
            if ((a_i ^ b_i) == {WIDTH{1'b1}}) begin
                assert_all_prop_R5: assert (cout_o == cin_i && sum_o == {WIDTH{~cin_i}});
            end
            if (a_i == '0 && b_i == '0) begin
                assert_zero_R9: assert (!cout_o && !ovf_o);
            end
        end
    end
endmodule

bind csa_adder csa_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .sum_o  (sum_o),
    .cout_o (cout_o),
    .ovf_o  (ovf_o)
);

// File: tb/csa_adder_test.sv
module csa_adder_test;
    localparam int W = 24;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [W-1:0] a, b;
    logic         cin;
    logic [W-1:0] sum_d, sum_u;
    logic         cout_d, cout_u, ovf_d, ovf_u;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    csa_adder uut (
        .a_i(a), .b_i(b), .cin_i(cin),
        .sum_o(sum_d), .cout_o(cout_d), .ovf_o(ovf_d)
    );

    csa_adder #(.WIDTH(24), .NBLK(4), .BLK_LEN({8'd4, 8'd8, 8'd9, 8'd3})) uut_uneq (
        .a_i(a), .b_i(b), .cin_i(cin),
        .sum_o(sum_u), .cout_o(cout_u), .ovf_o(ovf_u)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h (a=%h b=%h cin=%b)", req, act, exp, a, b, cin);
        end
    endtask

    task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv,
                         input string tag);
        logic [W:0]   full;
        logic [W-1:0] low;
        logic         c_in_msb, ovf_exp;
        @(negedge clk);
        a = av; b = bv; cin = cv;
        #1;
        full     = {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, cv};
        low      = {2'b0, av[W-2:0]} + {2'b0, bv[W-2:0]} + {{(W-1){1'b0}}, cv};
        c_in_msb = low[W-1];
        ovf_exp  = c_in_msb ^ full[W];
        chk({"R1 sum ", tag}, sum_d, full[W-1:0]);
        chk({"R2 cout ", tag}, {{(W-1){1'b0}}, cout_d}, {{(W-1){1'b0}}, full[W]});
        chk({"R3 ovf ", tag}, {{(W-1){1'b0}}, ovf_d}, {{(W-1){1'b0}}, ovf_exp});
        chk({"R4 ovf sign rule ", tag}, {{(W-1){1'b0}}, ovf_d},
            {{(W-1){1'b0}}, (av[W-1] == bv[W-1]) && (full[W-1] != av[W-1])});
        chk({"R8 uneven sum ", tag}, sum_u, full[W-1:0]);
        chk({"R8 uneven cout/ovf ", tag}, {{(W-2){1'b0}}, cout_u, ovf_u},
            {{(W-2){1'b0}}, full[W], ovf_exp});
    endtask

    task automatic t_zero_r9();
        apply('0, '0, 1'b0, "R9 zero cin0");
        chk("R9 sum zero", sum_d, 24'h0);
        apply('0, '0, 1'b1, "R9 zero cin1");
        chk("R9 sum one", sum_d, 24'h1);
    endtask

    task automatic t_all_prop_r5();
        apply(24'hA5A5A5, 24'h5A5A5A, 1'b0, "R5 prop cin0");
        chk("R5 sum ones", sum_d, 24'hFFFFFF);
        chk("R5 cout", {23'b0, cout_d}, 24'h0);
        apply(24'hFFFFFF, 24'h000000, 1'b1, "R5 prop cin1");
        chk("R5 sum zeros", sum_d, 24'h000000);
        chk("R5 cout", {23'b0, cout_d}, 24'h1);
        apply(24'h123456, ~24'h123456, 1'b1, "R5 prop mixed");
        chk("R5 uneven cout", {23'b0, cout_u}, 24'h1);
    endtask

    task automatic t_worst_r6();
        apply(24'hFFFFFF, 24'h800001, 1'b0, "R6 long carry");
        chk("R6 sum", sum_d, 24'h800000);
        chk("R6 cout", {23'b0, cout_d}, 24'h1);
        apply(24'h7FFFFF, 24'h000001, 1'b0, "R6 carry to sign");
        chk("R6 sum", sum_d, 24'h800000);
        chk("R6 ovf", {23'b0, ovf_d}, 24'h1);
    endtask

    task automatic t_ovf_r3();
        apply(24'h800000, 24'h800000, 1'b0, "R3 neg ovf");
        chk("R3 neg ovf flag", {23'b0, ovf_d}, 24'h1);
        apply(24'h400000, 24'h400000, 1'b0, "R3 pos ovf");
        chk("R3 pos ovf flag", {23'b0, ovf_d}, 24'h1);
        apply(24'hFFFFFF, 24'hFFFFFF, 1'b0, "R3 neg no ovf");
        chk("R3 no ovf flag", {23'b0, ovf_d}, 24'h0);
        apply(24'h800000, 24'h7FFFFF, 1'b1, "R3 mixed sign");
    endtask

    task automatic t_sub_r7();
        logic [W-1:0] x, y;
        x = 24'h001000; y = 24'h000FFF;
        apply(x, ~y, 1'b1, "R7 sub ge");
        chk("R7 diff", sum_d, x - y);
        chk("R7 no borrow", {23'b0, cout_d}, 24'h1);
        x = 24'h000005; y = 24'h000009;
        apply(x, ~y, 1'b1, "R7 sub lt");
        chk("R7 diff", sum_d, x - y);
        chk("R7 borrow", {23'b0, cout_d}, 24'h0);
    endtask

    task automatic t_random_r1();
        for (int n = 0; n < 300; n++) begin
            apply(W'($urandom), W'($urandom), 1'($urandom), "R1 R2 random");
        end
    endtask

    initial begin
        a = '0; b = '0; cin = 1'b0;
        void'($urandom(32'd7));
        #2;
        chk("R9 initial sum", sum_d, 24'h0);
        t_zero_r9();
        t_all_prop_r5();
        t_worst_r6();
        t_ovf_r3();
        t_sub_r7();
        t_random_r1();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule